// File: doc/BRIEF.md
# Write Buffering Bridge with Early Response

This block sits on the write path between a write manager and one downstream subordinate. It accepts an address request and then its data burst, holds both in small in-order queues, and sends them on to the subordinate without changing their order. The response the manager sees is chosen per request from bit 0 of the 4-bit cache attribute field. When that bit (the bufferable flag) is set, the bridge answers on its own once the last data beat has been accepted. When it is clear, the manager gets the subordinate's own response, relayed unchanged.

Every forwarded request keeps its address, length, size, burst type, protection, cache and QoS fields exactly as received. Requests are never split or merged. Only the ID is rewritten: all downstream requests use ID zero, so the subordinate answers in issue order, and an in-order tracker pairs each downstream response with the request that caused it. Downstream responses to requests that were already answered early are absorbed. If one of them reports an error (response bit 1 set), a sticky error flag is raised.

Top module: `wr_buf_bridge`

## Requirements
- R1: For a request with cache bit 0 set, the upstream response is valid in the cycle after the last data beat is accepted, with response code 0 (OKAY) and the request's ID, whether or not the downstream side has moved.
- R2: For a request with cache bit 0 clear, no upstream response is given until the downstream response arrives. The upstream response then carries the downstream response code and the request's original ID in the same cycle.
- R3: The upstream response of a non-bufferable request is given only after all older requests have received their downstream responses.
- R4: A forwarded request has the same address, length, size, burst, protection, cache and QoS values as the upstream request, and downstream ID 0.
- R5: Requests and data beats leave downstream in the order they were accepted upstream.
- R6: A downstream response for a request that was answered early produces no upstream response.
- R7: The address-ready output is low while DEPTH requests are waiting for downstream responses. The data-ready output is low while WDEPTH beats are held.
- R8: An absorbed downstream response with bit 1 set raises the error flag, which stays high until reset. Relayed responses do not affect the flag.
- R9: A request that has been accepted is offered downstream in the next cycle, so no entry waits in the buffer while the downstream side is ready.
- R10: Once the upstream response is valid, its valid, ID and code stay the same until it is accepted.
- R11: After reset, all valid outputs and the error flag are low, address-ready is high and data-ready is low.
- R12: Upstream acceptance is serial. Data-ready is high only after an address has been accepted and until its last beat is taken. Address-ready is low during the burst and while an early response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awvalid | input | 1 | Upstream address valid |
| s_awready | output | 1 | Upstream address ready |
| s_awid | input | ID_W | Upstream request ID |
| s_awaddr | input | ADDR_W | Upstream address |
| s_awlen | input | 8 | Beats minus one |
| s_awsize | input | 3 | Beat size code |
| s_awburst | input | 2 | Burst type |
| s_awprot | input | 3 | Protection attributes |
| s_awcache | input | 4 | Cache attributes (bit 0 bufferable) |
| s_awqos | input | 4 | QoS value |
| s_wvalid | input | 1 | Upstream data valid |
| s_wready | output | 1 | Upstream data ready |
| s_wdata | input | DATA_W | Upstream write data |
| s_wstrb | input | DATA_W/8 | Byte strobes |
| s_wlast | input | 1 | Last beat of burst |
| s_bvalid | output | 1 | Upstream response valid |
| s_bready | input | 1 | Upstream response ready |
| s_bid | output | ID_W | Response ID |
| s_bresp | output | 2 | Response code |
| m_awvalid | output | 1 | Downstream address valid |
| m_awready | input | 1 | Downstream address ready |
| m_awid | output | ID_W | Downstream ID (always 0) |
| m_awaddr | output | ADDR_W | Downstream address |
| m_awlen | output | 8 | Beats minus one |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type |
| m_awprot | output | 3 | Protection attributes |
| m_awcache | output | 4 | Cache attributes |
| m_awqos | output | 4 | QoS value |
| m_wvalid | output | 1 | Downstream data valid |
| m_wready | input | 1 | Downstream data ready |
| m_wdata | output | DATA_W | Downstream write data |
| m_wstrb | output | DATA_W/8 | Byte strobes |
| m_wlast | output | 1 | Last beat of burst |
| m_bvalid | input | 1 | Downstream response valid |
| m_bready | output | 1 | Downstream response ready |
| m_bresp | input | 2 | Downstream response code |
| err_sticky | output | 1 | Absorbed error seen since reset |

## Verification
A tracker that gets out of step with the downstream responses shows up on the next downstream response. A non-bufferable request is then either answered upstream with the wrong ID, or never answered while its downstream response is silently absorbed. The bench catches the missing response within a few cycles of giving the downstream response. A wrong bufferable decision shows in the cycle after the last beat, because the upstream response is either present when it must not be or absent when it must be. A queue pointer error shows as a changed forwarded field or a reordered data word as soon as that entry reaches the downstream ports.

// File: rtl/wbb_pkg.sv
// Shared field widths, bit positions and state type for the write buffering bridge.
// Assumes the 4-bit cache attribute field carries the bufferable flag in bit 0.
package wbb_pkg;
    localparam int LEN_W   = 8;
    localparam int SIZE_W  = 3;
    localparam int BURST_W = 2;
    localparam int PROT_W  = 3;
    localparam int CACHE_W = 4;
    localparam int QOS_W   = 4;
    localparam int RESP_W  = 2;
    localparam int BUF_BIT = 0;     // bufferable flag inside the cache field
    localparam int ERR_BIT = 1;     // response codes with this bit set are errors
    localparam logic [RESP_W-1:0] RESP_OKAY = 2'b00;

    typedef enum logic [1:0] {
        ST_ADDR  = 2'd0,
        ST_DATA  = 2'd1,
        ST_EARLY = 2'd2
    } acc_state_t;
endpackage

// File: rtl/wbb_fifo.sv
// In-order first-in first-out queue with a visible head entry.
// Assumes DEPTH >= 2; a push while full or a pop while empty is a caller error.
module wbb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign dout  = mem[rd_ptr];

    // Storage write, no reset needed on the data path.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wbb_bresp_arb.sv
// Upstream response selector: merges locally generated early responses with
// relayed downstream responses. Assumes relay_req, once raised, holds until
// relay_ack. A shown response is locked so it stays stable until taken.
module wbb_bresp_arb #(
    parameter int ID_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     early_req,
    input  logic [ID_W-1:0]          early_id,
    input  logic                     relay_req,
    input  logic [ID_W-1:0]          relay_id,
    input  logic [wbb_pkg::RESP_W-1:0] relay_resp,
    input  logic                     s_bready,
    output logic                     s_bvalid,
    output logic [ID_W-1:0]          s_bid,
    output logic [wbb_pkg::RESP_W-1:0] s_bresp,
    output logic                     early_ack,
    output logic                     relay_ack
);
    import wbb_pkg::*;

    logic relay_lock;
    logic early_show, relay_show;

    // Selection: a relay already on display keeps the channel; otherwise early wins.
    always_comb begin
        early_show = early_req && !relay_lock;
        relay_show = relay_req && !early_show;
        s_bvalid   = early_show || relay_show;
        s_bid      = early_show ? early_id : relay_id;
        s_bresp    = early_show ? RESP_OKAY : relay_resp;
        early_ack  = early_show && s_bready;
        relay_ack  = relay_show && s_bready;
    end

    // Lock remembers a relayed response that was offered but not yet accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) relay_lock <= 1'b0;
        else        relay_lock <= relay_show && !s_bready;
    end

    a_r10_resp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bid) && $stable(s_bresp)));
endmodule

// File: rtl/wr_buf_bridge.sv
// Write buffering bridge: accepts one request and its burst at a time, queues
// both, drains them downstream in order with ID 0, and answers upstream either
// early (cache bit 0 set) or by relaying the downstream response.
// Assumes the subordinate returns responses in order for a single ID.
module wr_buf_bridge #(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int WDEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        s_awvalid,
    output logic                        s_awready,
    input  logic [ID_W-1:0]             s_awid,
    input  logic [ADDR_W-1:0]           s_awaddr,
    input  logic [wbb_pkg::LEN_W-1:0]   s_awlen,
    input  logic [wbb_pkg::SIZE_W-1:0]  s_awsize,
    input  logic [wbb_pkg::BURST_W-1:0] s_awburst,
    input  logic [wbb_pkg::PROT_W-1:0]  s_awprot,
    input  logic [wbb_pkg::CACHE_W-1:0] s_awcache,
    input  logic [wbb_pkg::QOS_W-1:0]   s_awqos,
    input  logic                        s_wvalid,
    output logic                        s_wready,
    input  logic [DATA_W-1:0]           s_wdata,
    input  logic [DATA_W/8-1:0]         s_wstrb,
    input  logic                        s_wlast,
    output logic                        s_bvalid,
    input  logic                        s_bready,
    output logic [ID_W-1:0]             s_bid,
    output logic [wbb_pkg::RESP_W-1:0]  s_bresp,
    output logic                        m_awvalid,
    input  logic                        m_awready,
    output logic [ID_W-1:0]             m_awid,
    output logic [ADDR_W-1:0]           m_awaddr,
    output logic [wbb_pkg::LEN_W-1:0]   m_awlen,
    output logic [wbb_pkg::SIZE_W-1:0]  m_awsize,
    output logic [wbb_pkg::BURST_W-1:0] m_awburst,
    output logic [wbb_pkg::PROT_W-1:0]  m_awprot,
    output logic [wbb_pkg::CACHE_W-1:0] m_awcache,
    output logic [wbb_pkg::QOS_W-1:0]   m_awqos,
    output logic                        m_wvalid,
    input  logic                        m_wready,
    output logic [DATA_W-1:0]           m_wdata,
    output logic [DATA_W/8-1:0]         m_wstrb,
    output logic                        m_wlast,
    input  logic                        m_bvalid,
    output logic                        m_bready,
    input  logic [wbb_pkg::RESP_W-1:0]  m_bresp,
    output logic                        err_sticky
);
    import wbb_pkg::*;

    localparam int STRB_W = DATA_W / 8;
    localparam int AWQ_W  = ADDR_W + LEN_W + SIZE_W + BURST_W + PROT_W + CACHE_W + QOS_W;
    localparam int WQ_W   = DATA_W + STRB_W + 1;
    localparam int TRK_W  = ID_W + 1;

    acc_state_t      state;
    logic [ID_W-1:0] cur_id;
    logic            cur_buf;
    logic            aw_hs, w_hs;

    logic             awf_full, awf_empty;
    logic [AWQ_W-1:0] awf_dout;
    logic             wf_full, wf_empty;
    logic [WQ_W-1:0]  wf_dout;
    logic             trk_full, trk_empty;
    logic [TRK_W-1:0] trk_dout;
    logic [ID_W-1:0]  trk_head_id;
    logic             trk_head_buf;

    logic absorb, relay_req, early_ack, relay_ack;

    assign aw_hs     = s_awvalid && s_awready;
    assign w_hs      = s_wvalid && s_wready;
    assign s_awready = (state == ST_ADDR) && !trk_full;
    assign s_wready  = (state == ST_DATA) && !wf_full;

    // Upstream acceptance sequence: address, its data burst, then any early response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_ADDR;
            cur_id  <= '0;
            cur_buf <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: if (aw_hs) begin
                    state   <= ST_DATA;
                    cur_id  <= s_awid;
                    cur_buf <= s_awcache[BUF_BIT];
                end
                ST_DATA: if (w_hs && s_wlast)
                    state <= cur_buf ? ST_EARLY : ST_ADDR;
                ST_EARLY: if (early_ack)
                    state <= ST_ADDR;
                default: state <= ST_ADDR;
            endcase
        end
    end

    // Request queue; every field except the ID passes through untouched.
    wbb_fifo #(.W(AWQ_W), .DEPTH(DEPTH)) u_awq (
        .clk(clk), .rst_n(rst_n),
        .push(aw_hs),
        .din({s_awaddr, s_awlen, s_awsize, s_awburst, s_awprot, s_awcache, s_awqos}),
        .pop(m_awvalid && m_awready),
        .dout(awf_dout), .full(awf_full), .empty(awf_empty)
    );
    assign m_awvalid = !awf_empty;
    assign m_awid    = '0;
    assign {m_awaddr, m_awlen, m_awsize, m_awburst, m_awprot, m_awcache, m_awqos} = awf_dout;

    // Data beat queue.
    wbb_fifo #(.W(WQ_W), .DEPTH(WDEPTH)) u_wq (
        .clk(clk), .rst_n(rst_n),
        .push(w_hs),
        .din({s_wdata, s_wstrb, s_wlast}),
        .pop(m_wvalid && m_wready),
        .dout(wf_dout), .full(wf_full), .empty(wf_empty)
    );
    assign m_wvalid = !wf_empty;
    assign {m_wdata, m_wstrb, m_wlast} = wf_dout;

    // Outstanding tracker: original ID and bufferable decision, oldest first.
    wbb_fifo #(.W(TRK_W), .DEPTH(DEPTH)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .push(aw_hs),
        .din({s_awid, s_awcache[BUF_BIT]}),
        .pop(m_bvalid && m_bready),
        .dout(trk_dout), .full(trk_full), .empty(trk_empty)
    );
    assign {trk_head_id, trk_head_buf} = trk_dout;

    assign absorb    = m_bvalid && !trk_empty && trk_head_buf;
    assign relay_req = m_bvalid && !trk_empty && !trk_head_buf;
    assign m_bready  = absorb || relay_ack;

    wbb_bresp_arb #(.ID_W(ID_W)) u_barb (
        .clk(clk), .rst_n(rst_n),
        .early_req(state == ST_EARLY), .early_id(cur_id),
        .relay_req(relay_req), .relay_id(trk_head_id), .relay_resp(m_bresp),
        .s_bready(s_bready),
        .s_bvalid(s_bvalid), .s_bid(s_bid), .s_bresp(s_bresp),
        .early_ack(early_ack), .relay_ack(relay_ack)
    );

    // Sticky flag for errors on responses that were already answered early.
    always_ff @(posedge clk) begin
        if (!rst_n)                       err_sticky <= 1'b0;
        else if (absorb && m_bresp[ERR_BIT]) err_sticky <= 1'b1;
    end

    a_r1_early_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && w_hs && s_wlast && cur_buf) |=> s_bvalid);
    a_r2_relay_match: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && m_bready && !trk_head_buf) |->
        (s_bvalid && s_bready && s_bresp == m_bresp && s_bid == trk_head_id));
    a_r9_drain_start: assert property (@(posedge clk) disable iff (!rst_n)
        aw_hs |=> m_awvalid);
    a_r7_awq_room: assert property (@(posedge clk) disable iff (!rst_n)
        aw_hs |-> !awf_full);
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);
endmodule

// File: tb/sim_wr_buf_bridge.sv
module sim_wr_buf_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int ID_W = 4, ADDR_W = 32, DATA_W = 32;

    logic clk = 0, rst_n = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic s_awvalid = 0, s_awready;
    logic [ID_W-1:0] s_awid = 0;
    logic [ADDR_W-1:0] s_awaddr = 0;
    logic [7:0] s_awlen = 0;
    logic [2:0] s_awsize = 0, s_awprot = 0;
    logic [1:0] s_awburst = 0;
    logic [3:0] s_awcache = 0, s_awqos = 0;
    logic s_wvalid = 0, s_wready, s_wlast = 0;
    logic [DATA_W-1:0] s_wdata = 0;
    logic [3:0] s_wstrb = 4'hF;
    logic s_bvalid, s_bready = 1;
    logic [ID_W-1:0] s_bid;
    logic [1:0] s_bresp;
    logic m_awvalid, m_awready = 1;
    logic [ID_W-1:0] m_awid;
    logic [ADDR_W-1:0] m_awaddr;
    logic [7:0] m_awlen;
    logic [2:0] m_awsize, m_awprot;
    logic [1:0] m_awburst;
    logic [3:0] m_awcache, m_awqos;
    logic m_wvalid, m_wready = 1, m_wlast;
    logic [DATA_W-1:0] m_wdata;
    logic [3:0] m_wstrb;
    logic m_bvalid = 0, m_bready;
    logic [1:0] m_bresp = 0;
    logic err_sticky;

    wr_buf_bridge u0 (.*);

    int tests = 0, fails = 0;
    bit finished = 0;

    // Downstream capture
    int aw_cnt = 0, w_cnt = 0;
    logic [ADDR_W-1:0] cap_addr [32];
    logic [7:0] cap_len [32];
    logic [2:0] cap_size [32], cap_prot [32];
    logic [1:0] cap_burst [32];
    logic [3:0] cap_cache [32], cap_qos [32], cap_id [32];
    logic [DATA_W-1:0] cap_wdata [128];
    logic [ADDR_W-1:0] exp_addr [32];
    logic [7:0] exp_len [32];
    logic [2:0] exp_prot [32];
    logic [3:0] exp_cache [32], exp_qos [32];
    logic [DATA_W-1:0] exp_wdata [128];
    int n_aw = 0, n_w = 0;

    always @(posedge clk) if (rst_n) begin
        if (m_awvalid && m_awready) begin
            cap_addr[aw_cnt] = m_awaddr; cap_len[aw_cnt] = m_awlen;
            cap_size[aw_cnt] = m_awsize; cap_prot[aw_cnt] = m_awprot;
            cap_burst[aw_cnt] = m_awburst; cap_cache[aw_cnt] = m_awcache;
            cap_qos[aw_cnt] = m_awqos; cap_id[aw_cnt] = m_awid;
            aw_cnt++;
        end
        if (m_wvalid && m_wready) begin
            cap_wdata[w_cnt] = m_wdata; w_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Stall handling: optionally release downstream after three blocked cycles.
    bit release_on_stall = 0, stall_seen = 0;
    task automatic stall_hook(input int wc);
        if (wc == 3 && release_on_stall) begin
            stall_seen = 1; m_awready = 1; m_wready = 1;
        end
    endtask

    logic obs_bvalid; logic [ID_W-1:0] obs_bid; logic [1:0] obs_bresp;

    task automatic send_write(input logic [3:0] id, input logic [31:0] addr, input logic [7:0] len,
                              input logic [3:0] cache, input logic [2:0] prot, input logic [3:0] qos);
        int wc;
        exp_addr[n_aw] = addr; exp_len[n_aw] = len; exp_cache[n_aw] = cache;
        exp_prot[n_aw] = prot; exp_qos[n_aw] = qos; n_aw++;
        @(negedge clk);
        s_awvalid = 1; s_awid = id; s_awaddr = addr; s_awlen = len; s_awsize = 3'd2;
        s_awburst = 2'd1; s_awcache = cache; s_awprot = prot; s_awqos = qos;
        #1; wc = 0;
        while (!s_awready) begin @(negedge clk); #1; wc++; stall_hook(wc); end
        @(posedge clk); @(negedge clk);
        s_awvalid = 0;
        for (int b = 0; b <= int'(len); b++) begin
            s_wvalid = 1; s_wdata = addr ^ b; s_wlast = (b == int'(len));
            exp_wdata[n_w] = addr ^ b; n_w++;
            #1; wc = 0;
            while (!s_wready) begin @(negedge clk); #1; wc++; stall_hook(wc); end
            @(posedge clk); @(negedge clk);
        end
        s_wvalid = 0; s_wlast = 0; #1;
        obs_bvalid = s_bvalid; obs_bid = s_bid; obs_bresp = s_bresp;
    endtask

    task automatic dn_b(input logic [1:0] r);
        @(negedge clk);
        m_bvalid = 1; m_bresp = r; #1;
        while (!m_bready) begin @(negedge clk); #1; end
        obs_bvalid = s_bvalid; obs_bid = s_bid; obs_bresp = s_bresp;
        @(posedge clk); @(negedge clk);
        m_bvalid = 0;
    endtask

    task automatic wait_drain();
        while (aw_cnt < n_aw || w_cnt < n_w) @(negedge clk);
    endtask

    task automatic check_fwd(input int lo, input int hi);
        for (int k = lo; k < hi; k++) begin
            chk(cap_addr[k] == exp_addr[k], "R5 order/addr", cap_addr[k], exp_addr[k]);
            chk(cap_len[k] == exp_len[k] && cap_size[k] == 3'd2 && cap_burst[k] == 2'd1 &&
                cap_prot[k] == exp_prot[k] && cap_cache[k] == exp_cache[k] &&
                cap_qos[k] == exp_qos[k] && cap_id[k] == 0, "R4 fields",
                {cap_len[k], cap_prot[k], cap_cache[k], cap_qos[k], cap_id[k]},
                {exp_len[k], exp_prot[k], exp_cache[k], exp_qos[k], 4'h0});
        end
    endtask

    task automatic check_wdata(input int lo, input int hi);
        for (int k = lo; k < hi; k++)
            chk(cap_wdata[k] == exp_wdata[k], "R5 data order", cap_wdata[k], exp_wdata[k]);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!s_bvalid && !m_awvalid && !m_wvalid && !err_sticky, "R11 idle outputs",
            {s_bvalid, m_awvalid, m_wvalid, err_sticky}, 0);
        chk(s_awready && !s_wready, "R11/R12 ready after reset", {s_awready, s_wready}, 2'b10);
    endtask

    task automatic t_buffered();
        int a0 = n_aw, w0 = n_w;
        m_awready = 0; m_wready = 0; s_bready = 0;
        send_write(4'h5, 32'h1000, 8'd1, 4'b0011, 3'd1, 4'd7);
        chk(obs_bvalid && obs_bresp == 2'b00 && obs_bid == 4'h5, "R1 early response",
            {obs_bvalid, obs_bresp, obs_bid}, {1'b1, 2'b00, 4'h5});
        chk(m_awvalid, "R9 offered downstream", m_awvalid, 1);
        chk(!s_awready, "R12 no address while early pending", s_awready, 0);
        repeat (2) @(negedge clk);
        chk(s_bvalid && s_bid == 4'h5, "R10 held until ready", {s_bvalid, s_bid}, {1'b1, 4'h5});
        s_bready = 1;
        @(negedge clk);
        chk(!s_bvalid, "R10 cleared after accept", s_bvalid, 0);
        m_awready = 1; m_wready = 1;
        wait_drain();
        dn_b(2'b00);
        chk(!obs_bvalid, "R6 absorbed response", obs_bvalid, 0);
        check_fwd(a0, n_aw); check_wdata(w0, n_w);
    endtask

    task automatic t_nonbuf();
        int a0 = n_aw, w0 = n_w;
        send_write(4'h9, 32'h2000, 8'd2, 4'b0000, 3'd2, 4'd3);
        chk(!obs_bvalid, "R2 no local response", obs_bvalid, 0);
        wait_drain();
        repeat (3) @(negedge clk);
        chk(!s_bvalid, "R2 waits for downstream", s_bvalid, 0);
        dn_b(2'b10);
        chk(obs_bvalid && obs_bid == 4'h9 && obs_bresp == 2'b10, "R2 relayed response",
            {obs_bvalid, obs_bid, obs_bresp}, {1'b1, 4'h9, 2'b10});
        @(negedge clk);
        chk(!err_sticky, "R8 relayed error not sticky", err_sticky, 0);
        check_fwd(a0, n_aw); check_wdata(w0, n_w);
    endtask

    task automatic t_order();
        int a0 = n_aw, w0 = n_w;
        send_write(4'h1, 32'h3000, 8'd0, 4'b0001, 3'd0, 4'd1);
        chk(obs_bvalid && obs_bid == 4'h1, "R1 early A", {obs_bvalid, obs_bid}, {1'b1, 4'h1});
        send_write(4'h2, 32'h3100, 8'd1, 4'b0111, 3'd0, 4'd2);
        chk(obs_bvalid && obs_bid == 4'h2, "R1 early B", {obs_bvalid, obs_bid}, {1'b1, 4'h2});
        send_write(4'h3, 32'h3200, 8'd0, 4'b0010, 3'd3, 4'd15);
        wait_drain();
        check_fwd(a0, n_aw); check_wdata(w0, n_w);
        dn_b(2'b00);
        chk(!obs_bvalid, "R3/R6 first older absorbed", obs_bvalid, 0);
        @(negedge clk);
        chk(!s_bvalid, "R3 still waiting", s_bvalid, 0);
        dn_b(2'b00);
        chk(!obs_bvalid, "R3/R6 second older absorbed", obs_bvalid, 0);
        dn_b(2'b00);
        chk(obs_bvalid && obs_bid == 4'h3, "R3 relayed after older", {obs_bvalid, obs_bid}, {1'b1, 4'h3});
    endtask

    task automatic t_full();
        m_awready = 0; m_wready = 0;
        for (int k = 0; k < 4; k++)
            send_write(4'(k), 32'h4000 + 32'(k * 16), 8'd0, 4'b0011, 3'd0, 4'd0);
        @(negedge clk);
        chk(!s_awready, "R7 address held at DEPTH outstanding", s_awready, 0);
        m_awready = 1; m_wready = 1;
        wait_drain();
        for (int k = 0; k < 4; k++) begin
            dn_b(2'b00);
            chk(!obs_bvalid, "R6 absorbed in full test", obs_bvalid, 0);
        end
        @(negedge clk);
        chk(s_awready, "R7 address ready after drain", s_awready, 1);
        m_awready = 0; m_wready = 0; stall_seen = 0; release_on_stall = 1;
        send_write(4'hA, 32'h5000, 8'd7, 4'b0001, 3'd0, 4'd0);
        chk(!stall_seen, "R7 eight beats fit", stall_seen, 0);
        send_write(4'hB, 32'h5100, 8'd1, 4'b0001, 3'd0, 4'd0);
        chk(stall_seen, "R7 data held when beats full", stall_seen, 1);
        release_on_stall = 0;
        wait_drain();
        check_wdata(0, n_w);
        dn_b(2'b00); dn_b(2'b00);
    endtask

    task automatic t_err();
        send_write(4'hC, 32'h6000, 8'd0, 4'b0011, 3'd0, 4'd0);
        wait_drain();
        dn_b(2'b10);
        chk(!obs_bvalid, "R6 error absorbed", obs_bvalid, 0);
        @(negedge clk);
        chk(err_sticky, "R8 sticky set", err_sticky, 1);
        send_write(4'hD, 32'h6100, 8'd0, 4'b0001, 3'd0, 4'd0);
        wait_drain();
        dn_b(2'b00);
        @(negedge clk);
        chk(err_sticky, "R8 sticky holds", err_sticky, 1);
    endtask

    initial begin
        t_reset();
        t_buffered();
        t_nonbuf();
        t_order();
        t_full();
        t_err();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule